// File: doc/BRIEF.md
# Banked Array Access-Conflict Tracker

This block sits in front of a storage array split into several independently timed banks. Each clock cycle, up to `NUM_PORTS` requesters present an index. The block maps each index to a bank and decides in that same cycle whether the access may begin. The decision depends on whether the bank is still occupied by an earlier multi-cycle access. Requesters that are refused keep their request and retry later; the retry storage, the data paths and the array itself are not part of this block.

Ports are resolved in ascending order within a cycle. A port that wins an idle bank claims it at once, so higher-numbered ports in the same cycle see that claim. One case is an exception: a later port that asks for the very same index in the same cycle is also accepted. This lets two consumers of one access share a single grant without occupying the bank twice. Each claim records the index and a start-cycle stamp for its bank. A down-counter then holds the bank busy for a number of following cycles set by `LATENCY`. Setting `LATENCY` to zero turns conflict tracking off entirely. `START_BIT` is kept for configuration compatibility and has no effect on the mapping.

Top module: `bank_conflict_tracker`

## Requirements
- R1: The bank of a request is its index modulo `NUM_BANKS`, which is a power of two, so bank = the low log2(`NUM_BANKS`) index bits. `bank_busy[b]` is bit b of that output.
- R2: A port whose `req_valid` bit is 0 is never granted and claims no bank.
- R3: With `LATENCY` = 0, every valid request is granted in its cycle and `bank_busy` stays all zero.
- R4: A valid request to a bank whose `bank_busy` bit is 1 is refused.
- R5: A valid request to an idle bank not yet claimed by a lower-numbered port in the same cycle is granted. Ports are resolved from port 0 upward, and a later port with a different index to a bank claimed earlier that cycle is refused.
- R6: A later port whose index equals the index that claimed its bank earlier in the same cycle is granted. This repeat leaves the bank timing unchanged.
- R7: After a claim in cycle t, `bank_busy` for that bank is 1 in cycles t+1 through t+`LATENCY`-2 and is 0 from cycle t+`LATENCY`-1 on, when a new claim is accepted again. For `LATENCY` of 1 or 2, the bit never rises.
- R8: Refused requests, including repeats of the claiming index in later cycles, do not extend or restart a bank's busy period.
- R9: Synchronous active-high reset makes every bank idle: `bank_busy` reads zero in the first cycle after reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | NUM_PORTS | Per-port request present |
| req_idx | input | NUM_PORTS*IDX_W | Per-port index; port p uses bits [p*IDX_W +: IDX_W] |
| req_grant | output | NUM_PORTS | Per-port accept, combinational in the request cycle |
| bank_busy | output | NUM_BANKS | Per-bank occupied flag from earlier cycles |

## Verification
Several properties hold on every cycle and are checked by assertions. An invalid port is never granted. A port aimed at a bank whose `bank_busy` bit is set is refused. Port 0 always wins an idle bank. A bank's busy bit rises only after a claim and never stays high longer than `LATENCY`-2 cycles in a row. With zero latency, the busy vector stays zero. Other behaviours need the bench's scenarios. These include the same-cycle ordering between ports, the repeat-index exception, the exact cycle at which a bank frees up, the lack of extension from refused retries, and the index-to-bank mapping. The bench checks them with a cycle-accurate model of claim and release times, under both directed sequences and seeded random traffic.

// File: rtl/bct_pkg.sv
package bct_pkg;

    // Outcome of one port's request in the current cycle
    typedef enum logic [1:0] {
        DEC_IDLE   = 2'd0,  // no request on this port
        DEC_FRESH  = 2'd1,  // idle bank claimed
        DEC_REPEAT = 2'd2,  // same index, same cycle, shares the claim
        DEC_BLOCK  = 2'd3   // bank occupied by another access
    } dec_e;

    function automatic bit is_pow2(int unsigned n);
        return (n != 0) && ((n & (n - 1)) == 0);
    endfunction

    // Bank select: index modulo bank count (bank count is a power of two)
    function automatic int unsigned bank_of(longint unsigned idx, int unsigned nb);
        if (nb <= 1) return 0;
        return int'(idx % longint'(nb));
    endfunction

    function automatic int unsigned sel_bits(int unsigned nb);
        return (nb > 1) ? $clog2(nb) : 1;
    endfunction

    // Number of cycles a bank stays busy after its claim cycle
    function automatic int unsigned hold_cycles(int unsigned lat);
        return (lat >= 2) ? lat - 2 : 0;
    endfunction

endpackage

// File: rtl/bct_cycle_ctr.sv
module bct_cycle_ctr #(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst,
    output logic [CW-1:0] now
);
    always_ff @(posedge clk) begin
        if (rst) now <= '0;
        else     now <= now + 1'b1;
    end
endmodule

// File: rtl/bct_bank_slot.sv
module bct_bank_slot #(
    parameter int IW   = 8,
    parameter int CW   = 4,
    parameter int HOLD = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [IW-1:0] load_idx,
    input  logic [CW-1:0] now,
    output logic          busy,
    output logic [IW-1:0] idx_q,
    output logic [CW-1:0] start_q
);
    localparam int CNTW = (HOLD > 0) ? $clog2(HOLD + 1) : 1;

    logic [CNTW-1:0] remain;

    always_ff @(posedge clk) begin
        if (rst) begin
            remain  <= '0;
            idx_q   <= '0;
            start_q <= '0;
        end else if (load) begin
            remain  <= CNTW'(HOLD);
            idx_q   <= load_idx;
            start_q <= now;
        end else if (remain != '0) begin
            remain  <= remain - 1'b1;
        end
    end

    assign busy = (remain != '0);

    // R5: a bank becomes busy only as the result of a claim
    p_rise_from_claim_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(load));

    generate
        if (HOLD > 0) begin : g_window
            logic [CNTW:0] run;
            always_ff @(posedge clk) begin
                if (rst)       run <= '0;
                else if (busy) run <= run + 1'b1;
                else           run <= '0;
            end
            // R7: busy never lasts beyond the hold window in a row
            p_busy_window_r7: assert property (@(posedge clk) disable iff (rst)
                busy |-> (run < (CNTW+1)'(HOLD)));
        end else begin : g_nowin
            // R7: short latencies never show a registered busy
            p_never_busy_r7: assert property (@(posedge clk) disable iff (rst)
                !busy);
        end
    endgenerate
endmodule

// File: rtl/bct_resolve.sv
module bct_resolve
    import bct_pkg::*;
#(
    parameter int NP = 3,
    parameter int NB = 4,
    parameter int IW = 8,
    parameter int CW = 4
) (
    input  logic [NP-1:0]    valid,
    input  logic [NP*IW-1:0] idx,
    input  logic [NB-1:0]    busy,
    input  logic [NB*IW-1:0] rec_idx,
    input  logic [NB*CW-1:0] rec_start,
    input  logic [CW-1:0]    now,
    output logic [NP-1:0]    grant,
    output logic [NB-1:0]    load,
    output logic [NB*IW-1:0] load_idx
);
    logic          w_busy  [NB];
    logic [IW-1:0] w_idx   [NB];
    logic [CW-1:0] w_start [NB];
    logic [IW-1:0] pidx;
    int            bsel;
    dec_e          dec [NP];

    always_comb begin
        for (int b = 0; b < NB; b++) begin
            w_busy[b]  = busy[b];
            w_idx[b]   = rec_idx[b*IW +: IW];
            w_start[b] = rec_start[b*CW +: CW];
        end
        load     = '0;
        load_idx = '0;
        grant    = '0;
        pidx     = '0;
        bsel     = 0;
        // Ascending port order: a claim is visible to every later port
        for (int p = 0; p < NP; p++) begin
            pidx = idx[p*IW +: IW];
            bsel = int'(bank_of(64'(pidx), NB));
            if (!valid[p]) begin
                dec[p] = DEC_IDLE;
            end else if (w_busy[bsel]) begin
                if (w_start[bsel] == now && w_idx[bsel] == pidx)
                    dec[p] = DEC_REPEAT;
                else
                    dec[p] = DEC_BLOCK;
            end else begin
                dec[p]                  = DEC_FRESH;
                w_busy[bsel]            = 1'b1;
                w_idx[bsel]             = pidx;
                w_start[bsel]           = now;
                load[bsel]              = 1'b1;
                load_idx[bsel*IW +: IW] = pidx;
            end
            grant[p] = (dec[p] == DEC_FRESH) || (dec[p] == DEC_REPEAT);
        end
    end

    // R6: at most one fresh claim per bank per cycle
    always_comb begin
        for (int b = 0; b < NB; b++) begin
            int n;
            n = 0;
            for (int p = 0; p < NP; p++)
                if (dec[p] == DEC_FRESH && int'(bank_of(64'(idx[p*IW +: IW]), NB)) == b)
                    n++;
            a_single_claim_r6: assert (n <= 1);
        end
    end
endmodule

// File: rtl/bank_conflict_tracker.sv
module bank_conflict_tracker
    import bct_pkg::*;
#(
    parameter int NUM_PORTS = 3,
    parameter int NUM_BANKS = 4,
    parameter int IDX_W     = 8,
    parameter int LATENCY   = 4,
    parameter int START_BIT = 0
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [NUM_PORTS-1:0]       req_valid,
    input  logic [NUM_PORTS*IDX_W-1:0] req_idx,
    output logic [NUM_PORTS-1:0]       req_grant,
    output logic [NUM_BANKS-1:0]       bank_busy
);
    localparam int BW   = sel_bits(NUM_BANKS);
    localparam int CW   = $clog2(LATENCY + 2) + 1;
    localparam int HOLD = hold_cycles(LATENCY);

    generate
        if (!is_pow2(NUM_BANKS)) begin : g_bad_banks
            $error("NUM_BANKS must be a power of two");
        end
        if (START_BIT < 0) begin : g_bad_start
            $error("START_BIT must not be negative");
        end
    endgenerate

    generate
        if (LATENCY == 0) begin : g_untracked
            logic unused_idx;
            assign unused_idx = ^req_idx;
            assign req_grant  = req_valid;
            assign bank_busy  = '0;

            // R3: no bank is ever marked busy without latency
            p_zero_lat_idle_r3: assert property (@(posedge clk) disable iff (rst)
                bank_busy == '0);
        end else begin : g_tracked
            logic [CW-1:0]              now;
            logic [NUM_BANKS-1:0]       load;
            logic [NUM_BANKS*IDX_W-1:0] load_idx;
            logic [NUM_BANKS*IDX_W-1:0] rec_idx;
            logic [NUM_BANKS*CW-1:0]    rec_start;

            bct_cycle_ctr #(.CW(CW)) u_ctr (
                .clk (clk),
                .rst (rst),
                .now (now)
            );

            bct_resolve #(
                .NP(NUM_PORTS), .NB(NUM_BANKS), .IW(IDX_W), .CW(CW)
            ) u_resolve (
                .valid     (req_valid),
                .idx       (req_idx),
                .busy      (bank_busy),
                .rec_idx   (rec_idx),
                .rec_start (rec_start),
                .now       (now),
                .grant     (req_grant),
                .load      (load),
                .load_idx  (load_idx)
            );

            for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
                bct_bank_slot #(.IW(IDX_W), .CW(CW), .HOLD(HOLD)) u_slot (
                    .clk      (clk),
                    .rst      (rst),
                    .load     (load[b]),
                    .load_idx (load_idx[b*IDX_W +: IDX_W]),
                    .now      (now),
                    .busy     (bank_busy[b]),
                    .idx_q    (rec_idx[b*IDX_W +: IDX_W]),
                    .start_q  (rec_start[b*CW +: CW])
                );
            end

            for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port_chk
                logic [BW-1:0] pbank;
                assign pbank = BW'(bank_of(64'(req_idx[p*IDX_W +: IDX_W]), NUM_BANKS));

                // R2: an absent request is never granted
                p_no_grant_idle_r2: assert property (@(posedge clk) disable iff (rst)
                    !req_valid[p] |-> !req_grant[p]);
                // R4: a bank busy from earlier cycles refuses every port
                p_busy_refuse_r4: assert property (@(posedge clk) disable iff (rst)
                    (req_valid[p] && bank_busy[pbank]) |-> !req_grant[p]);
                if (p == 0) begin : g_first
                    // R5: port 0 sees no same-cycle claim and always wins an idle bank
                    p_first_port_r5: assert property (@(posedge clk) disable iff (rst)
                        (req_valid[0] && !bank_busy[pbank]) |-> req_grant[0]);
                end
            end
        end
    endgenerate
endmodule

// File: tb/bank_conflict_tracker_tb.sv
module bank_conflict_tracker_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NP  = 3;
    localparam int NB  = 4;
    localparam int IW  = 8;
    localparam int LAT = 4;

    logic             clk = 1'b0;
    logic             rst;
    logic [NP-1:0]    req_valid;
    logic [NP*IW-1:0] req_idx;
    logic [NP-1:0]    req_grant, grant_z;
    logic [NB-1:0]    bank_busy, busy_z;

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;
    int free_at [NB];
    logic [NP-1:0] g_last;
    logic [NB-1:0] b_last;

    always #(CLK_PERIOD/2) clk = ~clk;

    bank_conflict_tracker #(
        .NUM_PORTS(NP), .NUM_BANKS(NB), .IDX_W(IW), .LATENCY(LAT), .START_BIT(6)
    ) u_dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_idx(req_idx),
        .req_grant(req_grant), .bank_busy(bank_busy)
    );

    bank_conflict_tracker #(
        .NUM_PORTS(NP), .NUM_BANKS(NB), .IDX_W(IW), .LATENCY(0)
    ) u_zero (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_idx(req_idx),
        .req_grant(grant_z), .bank_busy(busy_z)
    );

    task automatic chk(bit ok, string tag, string what, int act, int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s cycle %0d: actual %0d expected %0d", tag, what, cyc, act, exp);
        end
    endtask

    function automatic int bank_of_idx(int i);
        return i % NB;
    endfunction

    // One request cycle: drive, check against the model, advance the model
    task automatic step(logic [NP-1:0] v, int i0, int i1, int i2);
        int ii [NP];
        bit claimed [NB];
        int cl_idx [NB];
        ii[0] = i0; ii[1] = i1; ii[2] = i2;
        for (int b = 0; b < NB; b++) begin claimed[b] = 0; cl_idx[b] = 0; end
        @(negedge clk);
        req_valid = v;
        for (int p = 0; p < NP; p++) req_idx[p*IW +: IW] = IW'(ii[p]);
        #1;
        g_last = req_grant;
        b_last = bank_busy;
        for (int b = 0; b < NB; b++)
            chk(bank_busy[b] == (cyc < free_at[b]), "R7", $sformatf("bank_busy[%0d]", b),
                int'(bank_busy[b]), int'(cyc < free_at[b]));
        for (int p = 0; p < NP; p++) begin
            int  b;
            bit  e;
            string tag;
            b = bank_of_idx(ii[p]);
            if (!v[p])                  begin e = 0; tag = "R2"; end
            else if (cyc < free_at[b])  begin e = 0; tag = "R4"; end
            else if (claimed[b])        begin e = (cl_idx[b] == ii[p]); tag = e ? "R6" : "R5"; end
            else begin e = 1; tag = "R5"; claimed[b] = 1; cl_idx[b] = ii[p]; end
            chk(req_grant[p] == e, tag, $sformatf("req_grant[%0d]", p), int'(req_grant[p]), int'(e));
            chk(grant_z[p] == v[p], "R3", $sformatf("zero-latency grant[%0d]", p),
                int'(grant_z[p]), int'(v[p]));
        end
        chk(busy_z == '0, "R3", "zero-latency bank_busy", int'(busy_z), 0);
        for (int b = 0; b < NB; b++)
            if (claimed[b]) free_at[b] = cyc + LAT - 1;
        @(posedge clk);
        cyc++;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        req_valid = '0;
        repeat (2) @(posedge clk);
        cyc += 2;
        @(negedge clk);
        rst = 1'b0;
        for (int b = 0; b < NB; b++) free_at[b] = 0;
        @(posedge clk);
        cyc++;
        #1;
        chk(bank_busy == '0, "R9", "bank_busy after reset", int'(bank_busy), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired: actual 0 expected 1");
        $display("%0d/%0d checks passed", n_checks + 1 - n_fail, n_checks + 1);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        rst = 1'b1;
        req_valid = '0;
        req_idx = '0;
        for (int b = 0; b < NB; b++) free_at[b] = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        chk(bank_busy == '0, "R9", "bank_busy out of reset", int'(bank_busy), 0);
        @(posedge clk);
        cyc = 0;

        // Same-cycle ordering and repeat exception on bank 1
        step(3'b111, 5, 9, 5);
        chk(g_last == 3'b101, "R6", "grant vector for 5,9,5", int'(g_last), 5);
        step(3'b001, 1, 0, 0);       // bank 1 held: refused (R4)
        chk(g_last[0] == 1'b0, "R4", "grant to busy bank", int'(g_last[0]), 0);
        step(3'b001, 5, 0, 0);       // repeat of claimer later: refused
        chk(g_last[0] == 1'b0, "R8", "late repeat refused", int'(g_last[0]), 0);
        step(3'b001, 13, 0, 0);      // cycle t+LAT-1: free again
        chk(g_last[0] == 1'b1, "R8", "release not extended by retries", int'(g_last[0]), 1);

        // Invalid request claims nothing
        step(3'b000, 2, 2, 2);
        step(3'b000, 0, 0, 0);
        chk(b_last[2] == 1'b0, "R2", "bank 2 after invalid request", int'(b_last[2]), 0);

        // Low index bits select the bank
        step(3'b111, 4, 9, 14);
        chk(g_last == 3'b111, "R1", "distinct banks all granted", int'(g_last), 7);
        step(3'b000, 0, 0, 0);
        chk(b_last == 4'b0111, "R1", "busy banks for 4,9,14", int'(b_last), 7);

        // Reset while banks are busy
        do_reset();

        // Seeded random traffic over a small index range
        for (int k = 0; k < 600; k++) begin
            step(NP'($urandom), int'($urandom % 16), int'($urandom % 16), int'($urandom % 16));
        end

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule